// File: doc/BRIEF.md
# Fractional 16x Oversampling Tick Generator

This block turns the peripheral clock into a stream of one-clock enable pulses at sixteen times the serial bit rate. The same pulse stream feeds both the serial transmitter and the serial receiver, so both sides share one timing reference. The rate is set by a divider word whose upper field counts in quarters of a clock. The six least significant bits of the word are ignored. A fixed offset of four quarters is always added, so a field of zero gives one pulse on every clock. That is the fastest setting, with a bit rate of fclk/16.

Fractional settings are produced by a phase accumulator rather than by stretching one period. Each enabled clock adds four quarters to the phase. When the phase reaches the programmed period (4 + field quarters), a pulse is issued and the period is subtracted. Over every 4 + field enabled clocks, exactly four pulses are produced, and no two pulses are further apart than the rounded-up period. When the enable is dropped, or the field is changed, the phase returns to zero and the pulse sequence starts again from the beginning.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `tick_o` is low in the clock after each sampled low reset. The phase also restarts from zero, so the first enabled cycle after reset counts as cycle 1.
- R2: The quarter field is `clkdiv[DIV_W-1:6]` and the period is P = 4 + field quarters. Over N consecutive enabled cycles that begin from a restart, exactly floor(4N/P) pulses are issued.
- R3: With a field of zero and `en` high, `tick_o` is high in every cycle after the first enabled sample.
- R4: Bits [5:0] of `clkdiv` have no effect. Changing them alone does not restart the phase and does not alter any pulse.
- R5: The nth enabled cycle since a restart (n = 1, 2, …) produces a pulse, visible one clock later, exactly when floor(4n/P) > floor(4(n-1)/P). As a result, with a field of 4 or more, no two pulses are adjacent.
- R6: While `en` is low, `tick_o` is low one clock later and the phase is cleared. The first pulse after re-enabling comes at enabled cycle ceil(P/4).
- R7: A cycle whose sampled quarter field differs from the field sampled one clock earlier produces no pulse and restarts the phase. The following cycle counts as enabled cycle 1 at the new period.
- R8: The largest field (all ones, 32767 with the default width) gives a period of 8192.75 clocks. The first pulse comes at enabled cycle 8193, and the phase never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables pulse generation; low clears the phase |
| clkdiv | input | DIV_W | Divider word; quarter field in bits DIV_W-1..6, bits 5..0 ignored |
| tick_o | output | 1 | One-clock 16x oversampling pulse |

## Verification
A wrong phase value in the accumulator does not stay hidden. It moves the next pulse by at least one cycle relative to the floor(4n/P) schedule, and the error shows at the next expected pulse. At most ceil(P/4) clocks after the fault, the pulse pattern diverges. A missed or spurious restart, whether from a field change or from the ignored low bits, shifts every later pulse. The per-cycle comparison therefore flags it within one period. The longest settings are run past two full pulses, so an overflow in the phase width would show as a wrong pulse count.

// File: rtl/frac_baud_pkg.sv
// Shared constants and helpers for the fractional tick generator.
// Assumes the divider word carries its quarter field above a fixed
// group of ignored low bits.
package frac_baud_pkg;
    // Number of ignored low bits below the quarter field.
    localparam int FRAC_LSB      = 6;
    // Fixed offset added to every period, in quarters of a clock.
    localparam int BASE_QUARTERS = 4;
    // Phase advance per enabled clock, in quarters.
    localparam int STEP_QUARTERS = 4;
    // Default divider word width (15-bit quarter field).
    localparam int DEF_DIV_W     = 21;
endpackage

// File: rtl/qdiv_field_track.sv
// Extracts the quarter field from the divider word and flags the
// cycle in which it differs from the field seen one clock earlier.
// Assumes the low FRAC_LSB bits are don't-care and never compared.
module qdiv_field_track
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    localparam int Q_W  = DIV_W - FRAC_LSB
) (
    input  logic           clk,
    input  logic [DIV_W-1:0] clkdiv,
    output logic [Q_W-1:0] field_o,
    output logic           change_o
);
    logic [Q_W-1:0] field_prev;

    assign field_o  = clkdiv[DIV_W-1:FRAC_LSB];
    assign change_o = (field_o != field_prev);

    // Remember the field of the previous cycle; tracked through reset too
    // so the first cycle after reset compares against a real value.
    always_ff @(posedge clk) begin
        field_prev <= field_o;
    end
endmodule

// File: rtl/qdiv_phase_acc.sv
// Phase accumulator: adds STEP_QUARTERS per running cycle and wraps by
// the period 4 + field, reporting a wrap in the same cycle.
// Assumes the field is stable whenever run is high.
module qdiv_phase_acc
    import frac_baud_pkg::*;
#(
    parameter int Q_W    = DEF_DIV_W - FRAC_LSB,
    localparam int ACC_W = Q_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [Q_W-1:0] field,
    output logic           wrap_o
);
    logic [ACC_W-1:0] phase;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] advanced;

    // Form the period and the candidate next phase.
    always_comb begin
        period   = {1'b0, field} + ACC_W'(BASE_QUARTERS);
        advanced = phase + ACC_W'(STEP_QUARTERS);
        wrap_o   = run && (advanced >= period);
    end

    // Advance or clear the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (wrap_o) begin
            phase <= advanced - period;
        end else begin
            phase <= advanced;
        end
    end
endmodule

// File: rtl/qdiv_pulse_reg.sv
// Registers the wrap indication into a one-clock output pulse.
// Assumes fire is already qualified by enable and restart.
module qdiv_pulse_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_o
);
    // Capture the pulse, forced low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional 16x oversampling tick generator. Produces four pulses every
// 4 + field clocks, spread by a phase accumulator; a new field or a low
// enable restarts the phase from zero.
// Assumes clkdiv is synchronous to clk.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    localparam int Q_W  = DIV_W - FRAC_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] clkdiv,
    output logic             tick_o
);
    logic [Q_W-1:0] field;
    logic           field_change;
    logic           run;
    logic           wrap;

    assign run = en && !field_change;

    qdiv_field_track #(.DIV_W(DIV_W)) u_track (
        .clk      (clk),
        .clkdiv   (clkdiv),
        .field_o  (field),
        .change_o (field_change)
    );

    qdiv_phase_acc #(.Q_W(Q_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .field  (field),
        .wrap_o (wrap)
    );

    qdiv_pulse_reg u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wrap),
        .pulse_o (tick_o)
    );
endmodule

// File: rtl/frac_baud_gen_props.sv
// Checker for frac_baud_gen, observing only its ports.
module frac_baud_gen_props
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    localparam int Q_W  = DIV_W - FRAC_LSB
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [DIV_W-1:0] clkdiv,
    input logic             tick_o
);
    logic [Q_W-1:0] fld;
    logic           was_reset;

    assign fld = clkdiv[DIV_W-1:FRAC_LSB];

    // Remember whether reset was sampled low at the previous edge.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
    end

    // R1: a sampled reset leaves the pulse low.
    always @(posedge clk) begin
        if (was_reset === 1'b1) begin
            p_low_after_reset_r1: assert (tick_o == 1'b0)
                else $error("tick high after reset");
        end
    end

    // R6: disabled cycle gives no pulse.
    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick_o);

    // R7: a new field suppresses the pulse of that cycle.
    p_restart_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fld != $past(fld)) |=> !tick_o);

    // R3: zero field with steady enable pulses every cycle.
    p_zero_field_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fld == '0 && $past(fld) == '0) |=> tick_o);

    // R5: with field >= 4, pulses are never adjacent.
    p_no_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en && fld >= Q_W'(4) && fld == $past(fld)) |=> !tick_o);
endmodule

bind frac_baud_gen frac_baud_gen_props #(.DIV_W(DIV_W)) u_props (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .clkdiv (clkdiv),
    .tick_o (tick_o)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    localparam int DIV_W = 21;
    localparam int Q_W   = DIV_W - 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] clkdiv = '0;
    logic             tick_o;

    int vectors = 0;
    int misses  = 0;
    int tick_count = 0;
    bit finished = 0;

    bit    exp_q[$];
    string tag_q[$];

    // Reference model state.
    int n_run = 0;
    int prev_field = 0;

    always #10 clk = ~clk;

    frac_baud_gen #(.DIV_W(DIV_W)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .clkdiv (clkdiv),
        .tick_o (tick_o)
    );

    // Monitor: compare each produced pulse with the oldest expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (tick_o) tick_count++;
            if (tick_o !== e) begin
                misses++;
                $display("FAIL %s: tick_o=%b expected %b at %0t", t, tick_o, e, $time);
            end
        end
    end

    // Driver: apply one cycle of inputs and queue the expected pulse.
    task automatic step(input logic r, input logic e, input logic [DIV_W-1:0] d,
                        input string tag);
        int  f;
        int  p;
        bit  x;
        @(negedge clk);
        rst_n  = r;
        en     = e;
        clkdiv = d;
        f = int'(d[DIV_W-1:6]);
        p = 4 + f;
        if (f != prev_field) begin
            n_run = 0;
            x = 0;
        end else if (!r || !e) begin
            n_run = 0;
            x = 0;
        end else begin
            n_run++;
            x = ((4 * n_run) / p) != ((4 * (n_run - 1)) / p);
        end
        if (!r) n_run = 0;
        prev_field = f;
        @(posedge clk);
        #1;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check_count(input int expected, input string tag);
        vectors++;
        if (tick_count != expected) begin
            misses++;
            $display("FAIL %s: pulse count=%0d expected %0d", tag, tick_count, expected);
        end
    endtask

    function automatic logic [DIV_W-1:0] word(input int f, input int low);
        return (DIV_W'(f) << 6) | DIV_W'(low & 63);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, word(0, 0), "R1");
        // R3: zero field, pulse every cycle
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, word(0, 0), "R3");
        // R5: field 1, four pulses every five cycles
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, word(1, 0), "R5");
        // R4: low bits change freely, field 2 stays
        for (int i = 0; i < 24; i++) step(1'b1, 1'b1, word(2, i * 13 + 5), "R4");
        // R2: field 7 over 44 cycles gives 16 pulses
        drain();
        tick_count = 0;
        step(1'b1, 1'b1, word(7, 0), "R2");
        for (int i = 0; i < 44; i++) step(1'b1, 1'b1, word(7, 0), "R2");
        drain();
        check_count(16, "R2");
        // R6: disable clears, re-enable restarts
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, word(7, 0), "R6");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, word(7, 0), "R6");
        // R7: field change mid-run
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, word(3, 0), "R7");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, word(10, 0), "R7");
        // R5: field 4 gives period 2
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, word(4, 0), "R5");
        // R2: field 400 over 300 cycles
        drain();
        tick_count = 0;
        step(1'b1, 1'b1, word(400, 0), "R2");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, word(400, 0), "R2");
        drain();
        check_count((4 * 300) / 404, "R2");
        // R8: largest field
        tick_count = 0;
        step(1'b1, 1'b1, word((1 << Q_W) - 1, 63), "R8");
        for (int i = 0; i < 20000; i++) step(1'b1, 1'b1, word((1 << Q_W) - 1, 63), "R8");
        drain();
        check_count((4 * 20000) / (4 + (1 << Q_W) - 1), "R8");
        // R1: reset in the middle of a run
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, word(1, 0), "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, word(1, 0), "R1");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, word(1, 0), "R1");
        drain();
        finished = 1;
        finish_run();
    end
endmodule